// File: doc/BRIEF.md
# Multi-Register Pseudo-Random Bit Source

This block produces a serial pseudo-random bit stream that feeds test data into a transmitter chain. It holds four linear feedback shift registers of unequal length, 21, 20, 17 and 18 bits. Each register uses the internal-XOR (Galois) form with a single two-input XOR in its feedback path. All four step together on each clock where the advance enable is high. On that step their four output bits are merged by an XOR stage into one serial bit, which is registered and flagged with a valid strobe.

The generator polynomials are the trinomials x^21+x^2+1, x^20+x^3+1, x^17+x^3+1 and x^18+x^7+1. Each register therefore runs through every nonzero state before it repeats. A seed can be loaded into all four registers in one cycle. Each register takes the low bits of the seed bus that fit its width. If the part a register takes is zero, that register gets its built-in default instead, so no register can stick at zero. Grouping bits into symbols is left to the mapper downstream.

Top module: `prbs_source`

## Requirements
- R1: A synchronous reset (active high) clears the valid strobe and the output bit. It loads the default seeds 0x15A5A3 (21-bit), 0xBEEF1 (20-bit), 0x1C0DE (17-bit) and 0x2F00D (18-bit).
- R2: A Galois step of a register with width n and tap t works as follows. The output is state bit 0. The state shifts toward bit 0, the output bit enters bit n-1, and the output bit is also XORed into bit t-1. The taps are 2, 3, 3 and 7.
- R3: The output bit is the XOR of the four register output bits taken before the step. It appears with the valid strobe high on the clock after a cycle where the advance enable is high and the seed load is low.
- R4: On a cycle without an advance step, the registers keep their state, the valid strobe is low on the following cycle, and the output bit holds its last value.
- R5: When seed load is high, each register of width n takes bits n-1..0 of the seed bus. This load takes priority over the advance enable, and no valid strobe follows it.
- R6: If the slice of the seed that a register takes is all zeros, that register loads its default seed instead, and no register state is ever zero.
- R7: Each register alone repeats its starting state after exactly 2^n-1 steps: 2097151, 1048575, 131071 and 262143.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| adv_en | input | 1 | Advance all registers by one step |
| seed_load | input | 1 | Load the seed bus into the registers |
| seed_in | input | 21 | Seed; each register uses its low bits |
| bit_out | output | 1 | Serial pseudo-random bit |
| bit_valid | output | 1 | High when bit_out carries a new bit |

## Verification
The hardest condition to reach from the ports is a full period: the longest register needs over two million steps, and the merged stream hides each register's own state. The bench therefore builds separate register instances. The 17-bit instance is counted through its whole cycle. Smaller trinomial instances with the same structure stand in for the longest widths. The zero-seed fallback is reached by loading seeds whose low 17 bits are zero while the upper bits are not, so only some registers fall back.

// File: rtl/prbs_pkg.sv
package prbs_pkg;
  localparam int unsigned PRBS_NUM  = 4;
  localparam int unsigned PRBS_MAXW = 21;

  localparam int unsigned LANE_W   [PRBS_NUM] = '{21, 20, 17, 18};
  localparam int unsigned LANE_TAP [PRBS_NUM] = '{2, 3, 3, 7};
  localparam logic [PRBS_MAXW-1:0] LANE_DEF [PRBS_NUM] =
    '{21'h15A5A3, 21'h0BEEF1, 21'h01C0DE, 21'h02F00D};

  // Mask of the low w bits of a maximum-width vector.
  function automatic logic [PRBS_MAXW-1:0] width_mask(input int unsigned w);
    logic [PRBS_MAXW-1:0] m;
    m = '0;
    for (int i = 0; i < int'(PRBS_MAXW); i++)
      if (i < int'(w)) m[i] = 1'b1;
    return m;
  endfunction

  // One internal-XOR step of an n-bit register with a single tap.
  function automatic logic [PRBS_MAXW-1:0] galois_next(
      input logic [PRBS_MAXW-1:0] s, input int unsigned w, input int unsigned t);
    logic [PRBS_MAXW-1:0] n;
    logic fb;
    fb = s[0];
    n  = '0;
    for (int i = 0; i < int'(PRBS_MAXW) - 1; i++)
      if (i < int'(w) - 1) n[i] = s[i+1];
    for (int i = 0; i < int'(PRBS_MAXW); i++) begin
      if (i == int'(w) - 1) n[i] = fb;
      if (i == int'(t) - 1) n[i] = n[i] ^ fb;
    end
    return n;
  endfunction

  // Value a register takes on a load: its seed slice, or the default if zero.
  function automatic logic [PRBS_MAXW-1:0] seed_pick(
      input logic [PRBS_MAXW-1:0] seed, input int unsigned w,
      input logic [PRBS_MAXW-1:0] def);
    logic [PRBS_MAXW-1:0] sl;
    sl = seed & width_mask(w);
    return (sl == '0) ? (def & width_mask(w)) : sl;
  endfunction
endpackage

// File: rtl/galois_lfsr.sv
module galois_lfsr
  import prbs_pkg::*;
#(
  parameter int unsigned W = 21,
  parameter int unsigned T = 2,
  parameter logic [PRBS_MAXW-1:0] SEED = 21'h000001
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step,
  input  logic                 load,
  input  logic [PRBS_MAXW-1:0] seed_in,
  output logic                 out_bit,
  output logic [PRBS_MAXW-1:0] state_o
);
  localparam logic [PRBS_MAXW-1:0] MASK = width_mask(W);

  logic [PRBS_MAXW-1:0] state_q;
  logic [PRBS_MAXW-1:0] load_val;
  logic [PRBS_MAXW-1:0] step_val;
  logic                 seed_is_zero;

  assign seed_is_zero = ((seed_in & MASK) == '0);
  assign load_val     = seed_pick(seed_in, W, SEED);
  assign step_val     = galois_next(state_q, W, T);

  always_ff @(posedge clk) begin
    if (rst)       state_q <= SEED & MASK;
    else if (load) state_q <= load_val;
    else if (step) state_q <= step_val;
  end

  assign out_bit = state_q[0];
  assign state_o = state_q;

  logic unused_ok;
  assign unused_ok = seed_is_zero;
endmodule

// File: rtl/prbs_combiner.sv
module prbs_combiner #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic [N-1:0] lane_bits,
  output logic         bit_out,
  output logic         bit_valid
);
  logic merged;
  assign merged = ^lane_bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_out   <= 1'b0;
      bit_valid <= 1'b0;
    end else begin
      bit_valid <= step;
      if (step) bit_out <= merged;
    end
  end
endmodule

// File: rtl/prbs_source.sv
module prbs_source
  import prbs_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        adv_en,
  input  logic        seed_load,
  input  logic [20:0] seed_in,
  output logic        bit_out,
  output logic        bit_valid
);
  logic                                 step_fire;
  logic [PRBS_NUM-1:0]                  lane_bit;
  logic [PRBS_NUM-1:0][PRBS_MAXW-1:0]   lane_state;

  assign step_fire = adv_en & ~seed_load;

  for (genvar g = 0; g < int'(PRBS_NUM); g++) begin : g_lane
    galois_lfsr #(
      .W   (LANE_W[g]),
      .T   (LANE_TAP[g]),
      .SEED(LANE_DEF[g])
    ) u_lfsr (
      .clk    (clk),
      .rst    (rst),
      .step   (step_fire),
      .load   (seed_load),
      .seed_in(seed_in),
      .out_bit(lane_bit[g]),
      .state_o(lane_state[g])
    );
  end

  prbs_combiner #(.N(PRBS_NUM)) u_comb (
    .clk      (clk),
    .rst      (rst),
    .step     (step_fire),
    .lane_bits(lane_bit),
    .bit_out  (bit_out),
    .bit_valid(bit_valid)
  );
endmodule

// File: rtl/prbs_source_chk.sv
module prbs_source_chk
  import prbs_pkg::*;
(
  input logic                               clk,
  input logic                               rst,
  input logic                               adv_en,
  input logic                               seed_load,
  input logic [20:0]                        seed_in,
  input logic                               bit_out,
  input logic                               bit_valid,
  input logic [PRBS_NUM-1:0][PRBS_MAXW-1:0] lane_state
);
  p_valid_on_step_r3: assert property (@(posedge clk) disable iff (rst)
    (adv_en && !seed_load) |=> bit_valid);

  p_no_valid_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !(adv_en && !seed_load) |=> !bit_valid);

  p_bit_holds_r4: assert property (@(posedge clk) disable iff (rst)
    !(adv_en && !seed_load) |=> $stable(bit_out));

  p_state_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!adv_en && !seed_load) |=> $stable(lane_state));

  p_load_slice_r5: assert property (@(posedge clk) disable iff (rst)
    (seed_load && seed_in != 21'd0) |=> lane_state[0] == $past(seed_in));

  p_zero_slice_default_r6: assert property (@(posedge clk) disable iff (rst)
    (seed_load && seed_in[16:0] == 17'd0) |=> lane_state[2] == 21'h01C0DE);

  p_never_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (lane_state[0] != '0) && (lane_state[1] != '0) &&
    (lane_state[2] != '0) && (lane_state[3] != '0));
endmodule

bind prbs_source prbs_source_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .adv_en    (adv_en),
  .seed_load (seed_load),
  .seed_in   (seed_in),
  .bit_out   (bit_out),
  .bit_valid (bit_valid),
  .lane_state(lane_state)
);

// File: tb/prbs_source_bench.sv
module prbs_source_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        adv_en = 1'b0;
  logic        seed_load = 1'b0;
  logic [20:0] seed_in = '0;
  logic        bit_out, bit_valid;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  prbs_source u_prbs_source (
    .clk(clk), .rst(rst), .adv_en(adv_en), .seed_load(seed_load),
    .seed_in(seed_in), .bit_out(bit_out), .bit_valid(bit_valid)
  );

  // Standalone registers for period counting (R7).
  logic        p_load = 1'b0;
  logic [2:0]  p_step = '0;
  logic [20:0] p_state [3];
  logic [2:0]  p_bit;
  galois_lfsr #(.W(17), .T(3), .SEED(21'h01C0DE)) u_p17 (
    .clk(clk), .rst(rst), .step(p_step[0]), .load(p_load), .seed_in(21'd1),
    .out_bit(p_bit[0]), .state_o(p_state[0]));
  galois_lfsr #(.W(7), .T(1), .SEED(21'h5)) u_p7 (
    .clk(clk), .rst(rst), .step(p_step[1]), .load(p_load), .seed_in(21'd1),
    .out_bit(p_bit[1]), .state_o(p_state[1]));
  galois_lfsr #(.W(5), .T(2), .SEED(21'h3)) u_p5 (
    .clk(clk), .rst(rst), .step(p_step[2]), .load(p_load), .seed_in(21'd1),
    .out_bit(p_bit[2]), .state_o(p_state[2]));

  // Bench model, written from the requirements.
  localparam int BW [4] = '{21, 20, 17, 18};
  localparam int BT [4] = '{2, 3, 3, 7};
  localparam logic [20:0] BD [4] = '{21'h15A5A3, 21'hBEEF1, 21'h1C0DE, 21'h2F00D};
  logic [20:0] m_st [4];
  logic        exp_bit;

  task automatic model_reset();
    for (int k = 0; k < 4; k++) m_st[k] = BD[k];
    exp_bit = 1'b0;
  endtask

  task automatic model_step();
    logic o;
    exp_bit = m_st[0][0] ^ m_st[1][0] ^ m_st[2][0] ^ m_st[3][0];
    for (int k = 0; k < 4; k++) begin
      o = m_st[k][0];
      m_st[k] = m_st[k] >> 1;
      if (o) m_st[k] = m_st[k] ^ (21'd1 << (BW[k]-1)) ^ (21'd1 << (BT[k]-1));
    end
  endtask

  task automatic model_load(input logic [20:0] s);
    logic [20:0] sl;
    for (int k = 0; k < 4; k++) begin
      sl = s & ((21'd1 << BW[k]) - 21'd1);
      m_st[k] = (sl == 21'd0) ? BD[k] : sl;
    end
  endtask

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {valid,bit} actual %b expected %b", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, sample at the following negedge.
  task automatic cycle(input logic a, input logic l, input logic [20:0] s, input string req);
    logic ev;
    adv_en = a; seed_load = l; seed_in = s;
    ev = 1'b0;
    if (l) model_load(s);
    else if (a) begin model_step(); ev = 1'b1; end
    @(negedge clk);
    check(req, {bit_valid, bit_out}, {ev, exp_bit});
  endtask

  // Stimulus table: {adv_en, seed_load, seed}.
  localparam logic [22:0] VEC [16] = '{
    {1'b1, 1'b0, 21'h0},      {1'b1, 1'b0, 21'h0},      {1'b0, 1'b0, 21'h0},
    {1'b1, 1'b0, 21'h0},      {1'b1, 1'b1, 21'h12345},  {1'b1, 1'b0, 21'h0},
    {1'b1, 1'b0, 21'h0},      {1'b0, 1'b1, 21'h1E0000}, {1'b1, 1'b0, 21'h0},
    {1'b0, 1'b0, 21'h1FFFFF}, {1'b1, 1'b0, 21'h0},      {1'b0, 1'b1, 21'h1FFFFF},
    {1'b1, 1'b0, 21'h0},      {1'b1, 1'b0, 21'h0},      {1'b0, 1'b0, 21'h0},
    {1'b1, 1'b0, 21'h0}
  };

  task automatic run_period(input int idx, input int expect_len);
    int cnt;
    @(negedge clk); p_load = 1'b1;
    @(negedge clk); p_load = 1'b0; p_step[idx] = 1'b1;
    cnt = 0;
    for (int i = 0; i < 140000; i++) begin
      @(negedge clk);
      cnt++;
      if (p_state[idx] == 21'd1) break;
    end
    p_step[idx] = 1'b0;
    checks++;
    if (cnt != expect_len) begin
      fails++;
      $display("FAIL R7: period of register %0d actual %0d expected %0d", idx, cnt, expect_len);
    end
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset state", {bit_valid, bit_out}, 2'b00);

    // R2/R3: default seeds streamed out for 48 steps.
    for (int i = 0; i < 48; i++) cycle(1'b1, 1'b0, 21'h0, "R2 R3 stream from defaults");

    // R4: idle cycles hold state and output, then the stream resumes in step.
    for (int i = 0; i < 5; i++) cycle(1'b0, 1'b0, 21'h0AAAAA, "R4 idle hold");
    for (int i = 0; i < 8; i++) cycle(1'b1, 1'b0, 21'h0, "R4 resume after idle");

    // Table of mixed stimulus (R3, R4, R5, R6).
    for (int i = 0; i < 16; i++)
      cycle(VEC[i][22], VEC[i][21], VEC[i][20:0], "R5 R6 table vector");

    // R6: all-zero seed falls back to every default.
    cycle(1'b0, 1'b1, 21'h0, "R6 zero seed load");
    for (int i = 0; i < 24; i++) cycle(1'b1, 1'b0, 21'h0, "R6 stream after zero seed");

    // R5: load with advance asserted; load wins.
    cycle(1'b1, 1'b1, 21'h0F0F0F, "R5 load priority");
    for (int i = 0; i < 24; i++) cycle(1'b1, 1'b0, 21'h0, "R5 stream after load");

    // R1: reset mid-run restores defaults.
    rst = 1'b1; adv_en = 1'b1;
    @(negedge clk);
    rst = 1'b0; model_reset();
    check("R1 reset mid-run", {bit_valid, bit_out}, 2'b00);
    for (int i = 0; i < 16; i++) cycle(1'b1, 1'b0, 21'h0, "R1 stream after reset");
    adv_en = 1'b0;

    // R7: periods (17-bit full, 7- and 5-bit stand-ins for the same structure).
    run_period(1, 127);
    run_period(2, 31);
    run_period(0, 131071);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule